// File: doc/BRIEF.md
# SDRAM Burst Read Output Engine

This block is the read data path on the device side of a four-bank synchronous DRAM. A bank is opened by an activate command that records a row for that bank. A read command then names a bank and a starting column. From that point the engine walks the burst column sequence, fetches one word per cycle from the array, and presents the words on the data output with an output enable.

The burst length and the CAS latency come from mode inputs. Both are captured when the read is accepted, so the commands themselves carry no length or latency. Fixed bursts of 1, 2, 4 or 8 words end by themselves. A full-page burst cycles through all 512 columns of the row until a burst stop arrives.

The output enable rises one cycle before the first word. It falls in the cycle after the last word. The array is modelled as a fixed data pattern built from bank, row and column, so every word is predictable.

Top module: `sdram_burst_rd`

## Requirements
- R1: After reset, `dq_oe` and `rd_err` are low and `dq_out` is all zeros. No bank is open.
- R2: `act_valid` opens bank `act_bank` with row `act_row`, replacing any row held before. A read to an open bank returns words of the form bits[15:14] = row[6:5] XOR bank, bits[13:9] = row[4:0], bits[8:0] = column. `rd_err` stays low for such a read.
- R3: `mode_bl` codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 words. Codes 4 to 6 give one word. For a fixed burst of length L, word k comes from column (start with its low log2(L) bits cleared) plus ((start + k) mod L).
- R4: With `mode_cl3` at 0 the latency is 2, and with it at 1 the latency is 3. If the read is accepted in cycle 0, `dq_oe` goes high in cycle CL-1 and word 0 appears in cycle CL. Word k appears in cycle CL+k.
- R5: For a fixed burst of L words that is not stopped, `dq_oe` is high from cycle CL-1 through cycle CL+L-1 and low in cycle CL+L.
- R6: `mode_bl` code 7 selects a full-page burst. The column increments from 511 to 0 and the burst keeps going. If `burst_stop` is high in cycle s (s ≥ 1, with no read in that cycle), the last word is output in cycle s+CL-1 and `dq_oe` is low in cycle s+CL. A stop also cuts short a fixed burst in the same way.
- R7: A read to a bank that is not open is ignored: no output enable and no data. `rd_err` is high for exactly the next cycle.
- R8: Changing `mode_bl` or `mode_cl3` after a read has been accepted has no effect on that burst.
- R9: Whenever `dq_oe` is low, `dq_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_valid | input | 1 | Activate command strobe |
| act_bank | input | 2 | Bank to open |
| act_row | input | 12 | Row to record for the bank |
| mode_bl | input | 3 | Burst length code (0/1/2/3 = 1/2/4/8, 7 = full page) |
| mode_cl3 | input | 1 | 0 selects latency 2, 1 selects latency 3 |
| rd_valid | input | 1 | Read command strobe |
| rd_bank | input | 2 | Bank for the read |
| rd_col | input | 9 | Starting column |
| burst_stop | input | 1 | Ends the running burst |
| dq_out | output | 16 | Read data, zero while not enabled |
| dq_oe | output | 1 | Output driver enable (high = low impedance) |
| rd_err | output | 1 | One-cycle pulse for a read to a closed bank |

## Verification
The bench first targets start columns near the top of an aligned block. An engine that carries into the upper column bits would step out of the block, for example reading column 16 after 15 on a length-8 burst starting at 13. Full-page bursts are started at 508 and run past 511. A design that saturates or stops there would either repeat 511 or drop the enable early.

Every burst is checked cycle by cycle under both latencies. A design that ties the enable to the data stage instead of one stage earlier would miss the preamble cycle. Bursts are stopped at varied offsets, which exposes an off-by-one in the stop path as one word too many or too few. The mode inputs are changed right after a read is accepted. Reads to a closed bank must neither produce an enable nor skip the error pulse.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

    typedef enum logic [2:0] {
        BLC_ONE  = 3'd0,
        BLC_TWO  = 3'd1,
        BLC_FOUR = 3'd2,
        BLC_EIGHT = 3'd3,
        BLC_PAGE = 3'd7
    } bl_code_e;

    // log2 of the burst length for fixed codes; reserved codes act as one word
    function automatic logic [1:0] bl_log2(input logic [2:0] code);
        logic [1:0] lg;
        case (code)
            BLC_TWO:   lg = 2'd1;
            BLC_FOUR:  lg = 2'd2;
            BLC_EIGHT: lg = 2'd3;
            default:   lg = 2'd0;
        endcase
        return lg;
    endfunction

    function automatic logic bl_is_page(input logic [2:0] code);
        return code == BLC_PAGE;
    endfunction

endpackage

// File: rtl/sdram_bank_rows.sv
module sdram_bank_rows #(
    parameter int BANKS  = 4,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           act_valid,
    input  logic [BANK_W-1:0]              act_bank,
    input  logic [ROW_W-1:0]               act_row,
    output logic [BANKS-1:0]               open_vec,
    output logic [BANKS-1:0][ROW_W-1:0]    open_row
);

    typedef struct packed {
        logic [BANKS-1:0]            open;
        logic [BANKS-1:0][ROW_W-1:0] row;
    } tbl_t;

    tbl_t             tbl_d, tbl_q;
    logic [BANKS-1:0] hit;

    // per-bank decode of the activate command
    for (genvar g = 0; g < BANKS; g++) begin : g_hit
        assign hit[g] = act_valid && (act_bank == BANK_W'(g));
    end

    always_comb begin
        tbl_d = tbl_q;
        for (int i = 0; i < BANKS; i++) begin
            if (hit[i]) begin
                tbl_d.open[i] = 1'b1;
                tbl_d.row[i]  = act_row;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign open_vec = tbl_q.open;
    assign open_row = tbl_q.row;

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import sdram_rd_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int DATA_W = 16,
    parameter int CL_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [BANK_W-1:0]  start_bank,
    input  logic [ROW_W-1:0]   start_row,
    input  logic [COL_W-1:0]   start_col,
    input  logic [2:0]         bl_code,
    input  logic [CL_W-1:0]    cl_in,
    input  logic               stop,
    output logic               seq_valid,
    output logic [DATA_W-1:0]  seq_data,
    output logic [CL_W-1:0]    seq_cl
);

    localparam int CAT_W = BANK_W + ROW_W + COL_W;

    typedef struct packed {
        logic              valid;
        logic              page;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [COL_W-1:0]  wrap;   // column bits that count; the rest stay fixed
        logic [COL_W-1:0]  left;   // words still to come in a fixed burst
        logic [CL_W-1:0]   cl;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic [COL_W-1:0] len_m1;
    logic [COL_W-1:0] step;
    logic             page_sel;
    logic [CAT_W-1:0] cat;

    always_comb begin
        page_sel = bl_is_page(bl_code);
        len_m1   = (COL_W'(1) << bl_log2(bl_code)) - COL_W'(1);
        step     = seq_q.col + COL_W'(1);
        seq_d    = seq_q;
        if (start) begin
            seq_d.valid = 1'b1;
            seq_d.page  = page_sel;
            seq_d.bank  = start_bank;
            seq_d.row   = start_row;
            seq_d.col   = start_col;
            seq_d.wrap  = page_sel ? '1 : len_m1;
            seq_d.left  = page_sel ? '0 : len_m1;
            seq_d.cl    = cl_in;
        end else if (seq_q.valid) begin
            if (stop || (!seq_q.page && seq_q.left == '0)) begin
                seq_d.valid = 1'b0;
            end else begin
                seq_d.col = (seq_q.col & ~seq_q.wrap) | (step & seq_q.wrap);
                if (!seq_q.page) seq_d.left = seq_q.left - COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    // array model: the word is a fixed pattern of bank, row and column
    always_comb begin
        cat      = {seq_q.bank, seq_q.row, seq_q.col};
        seq_data = cat[DATA_W-1:0] ^ {seq_q.bank, {(DATA_W-BANK_W){1'b0}}};
    end

    assign seq_valid = seq_q.valid;
    assign seq_cl    = seq_q.cl;

endmodule

// File: rtl/sdram_dq_pipe.sv
module sdram_dq_pipe #(
    parameter int DATA_W = 16,
    parameter int CL_W   = 2,
    parameter int CL_MAX = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_data,
    input  logic [CL_W-1:0]    in_cl,
    output logic [DATA_W-1:0]  dq_out,
    output logic               dq_oe
);

    localparam int DEPTH = CL_MAX - 1;

    typedef struct packed {
        logic              valid;
        logic [CL_W-1:0]   cl;
        logic [DATA_W-1:0] data;
    } stg_t;

    stg_t [DEPTH-1:0] pipe_d, pipe_q;
    stg_t [DEPTH:0]   view;    // view[0] is the sequencer, view[i] the i-th delay

    assign view[0] = '{valid: in_valid, cl: in_cl, data: in_data};
    for (genvar g = 1; g <= DEPTH; g++) begin : g_view
        assign view[g] = pipe_q[g-1];
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) pipe_d[i] = view[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    // stage i carries a word whose latency is i+1 to the pins; one stage
    // earlier opens the driver a cycle ahead of the data
    always_comb begin
        dq_out = '0;
        dq_oe  = 1'b0;
        for (int i = 0; i <= DEPTH; i++) begin
            if (view[i].valid && view[i].cl == CL_W'(i + 1)) begin
                dq_out = view[i].data;
                dq_oe  = 1'b1;
            end
            if ((i + 2 <= CL_MAX) && view[i].valid && view[i].cl == CL_W'(i + 2)) begin
                dq_oe = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sdram_burst_rd.sv
module sdram_burst_rd
    import sdram_rd_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int BANK_W = $clog2(BANKS),
    parameter int ROW_W  = 12,
    parameter int COL_W  = 9,
    parameter int DATA_W = 16,
    parameter int CL_W   = 2,
    parameter int CL_MAX = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               act_valid,
    input  logic [BANK_W-1:0]  act_bank,
    input  logic [ROW_W-1:0]   act_row,
    input  logic [2:0]         mode_bl,
    input  logic               mode_cl3,
    input  logic               rd_valid,
    input  logic [BANK_W-1:0]  rd_bank,
    input  logic [COL_W-1:0]   rd_col,
    input  logic               burst_stop,
    output logic [DATA_W-1:0]  dq_out,
    output logic               dq_oe,
    output logic               rd_err
);

    typedef struct packed {
        logic err;
    } ctl_t;

    logic [BANKS-1:0]            open_vec;
    logic [BANKS-1:0][ROW_W-1:0] open_row;
    logic                        rd_accept;
    logic [CL_W-1:0]             cl_sel;
    logic                        seq_valid;
    logic [DATA_W-1:0]           seq_data;
    logic [CL_W-1:0]             seq_cl;
    ctl_t                        ctl_d, ctl_q;

    sdram_bank_rows #(
        .BANKS (BANKS),
        .BANK_W(BANK_W),
        .ROW_W (ROW_W)
    ) u_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_valid(act_valid),
        .act_bank (act_bank),
        .act_row  (act_row),
        .open_vec (open_vec),
        .open_row (open_row)
    );

    always_comb begin
        rd_accept = rd_valid && open_vec[rd_bank];
        cl_sel    = mode_cl3 ? CL_W'(3) : CL_W'(2);
        ctl_d.err = rd_valid && !open_vec[rd_bank];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    sdram_burst_seq #(
        .COL_W (COL_W),
        .BANK_W(BANK_W),
        .ROW_W (ROW_W),
        .DATA_W(DATA_W),
        .CL_W  (CL_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (rd_accept),
        .start_bank(rd_bank),
        .start_row (open_row[rd_bank]),
        .start_col (rd_col),
        .bl_code   (mode_bl),
        .cl_in     (cl_sel),
        .stop      (burst_stop),
        .seq_valid (seq_valid),
        .seq_data  (seq_data),
        .seq_cl    (seq_cl)
    );

    sdram_dq_pipe #(
        .DATA_W(DATA_W),
        .CL_W  (CL_W),
        .CL_MAX(CL_MAX)
    ) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(seq_valid),
        .in_data (seq_data),
        .in_cl   (seq_cl),
        .dq_out  (dq_out),
        .dq_oe   (dq_oe)
    );

    assign rd_err = ctl_q.err;

endmodule

// File: rtl/sdram_burst_rd_chk.sv
module sdram_burst_rd_chk #(
    parameter int BANKS  = 4,
    parameter int BANK_W = 2,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_valid,
    input logic [BANK_W-1:0] rd_bank,
    input logic              rd_err,
    input logic              dq_oe,
    input logic [DATA_W-1:0] dq_out,
    input logic [BANKS-1:0]  open_vec
);

    assert_err_on_closed_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !open_vec[rd_bank]) |=> rd_err);

    assert_err_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> $past(rd_valid));

    assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq_out == '0));

    assert_preamble_then_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |=> dq_oe);

endmodule

bind sdram_burst_rd sdram_burst_rd_chk #(
    .BANKS (BANKS),
    .BANK_W(BANK_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_valid(rd_valid),
    .rd_bank (rd_bank),
    .rd_err  (rd_err),
    .dq_oe   (dq_oe),
    .dq_out  (dq_out),
    .open_vec(open_vec)
);

// File: tb/sdram_burst_rd_test.sv
`timescale 1ns/1ps
module sdram_burst_rd_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        act_valid = 1'b0;
    logic [1:0]  act_bank = '0;
    logic [11:0] act_row = '0;
    logic [2:0]  mode_bl = '0;
    logic        mode_cl3 = 1'b0;
    logic        rd_valid = 1'b0;
    logic [1:0]  rd_bank = '0;
    logic [8:0]  rd_col = '0;
    logic        burst_stop = 1'b0;
    logic [15:0] dq_out;
    logic        dq_oe;
    logic        rd_err;

    int total = 0;
    int bad = 0;
    logic [11:0] rows [4];

    always #2 clk = ~clk;

    sdram_burst_rd uut (
        .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_bank(act_bank),
        .act_row(act_row), .mode_bl(mode_bl), .mode_cl3(mode_cl3),
        .rd_valid(rd_valid), .rd_bank(rd_bank), .rd_col(rd_col),
        .burst_stop(burst_stop), .dq_out(dq_out), .dq_oe(dq_oe), .rd_err(rd_err)
    );

    function automatic logic [15:0] exp_word(logic [1:0] b, logic [11:0] r, logic [8:0] c);
        return {r[6:0], c} ^ {b, 14'b0};
    endfunction

    function automatic int burst_len(logic [2:0] code);
        if (code <= 3'd3) return 1 << code;
        return 1;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic activate(logic [1:0] b, logic [11:0] r);
        @(negedge clk);
        act_valid = 1'b1; act_bank = b; act_row = r;
        rows[b] = r;
        @(negedge clk);
        act_valid = 1'b0;
    endtask

    // read in cycle 0, optional stop in cycle stop_at, checked every cycle
    task automatic run_read(logic [1:0] b, logic [8:0] c, logic [2:0] blc,
                            logic cl3, int stop_at, bit scramble);
        int  cl   = cl3 ? 3 : 2;
        bit  page = (blc == 3'd7);
        int  blen = burst_len(blc);
        int  n;
        logic [8:0] mask;
        string tag_oe;
        string tag_d;
        if (page) begin
            n = stop_at; mask = 9'h1ff;
        end else begin
            n = (stop_at > 0 && stop_at < blen) ? stop_at : blen;
            mask = 9'(blen - 1);
        end
        tag_oe = page ? "R6" : (stop_at > 0 ? "R6" : "R5");
        tag_d  = scramble ? "R8" : (page ? "R6" : "R3");
        for (int cy = 0; cy <= cl + n + 1; cy++) begin
            @(negedge clk);
            if (cy < cl - 1 || cy > cl + n - 1)
                check(tag_oe, 32'(dq_oe), 32'd0);
            else
                check("R4", 32'(dq_oe), 32'd1);
            if (cy >= cl && cy <= cl + n - 1) begin
                logic [8:0] col = (c & ~mask) | (9'(c + 9'(cy - cl)) & mask);
                check(tag_d, 32'(dq_out), 32'(exp_word(b, rows[b], col)));
            end else if (cy != cl - 1) begin
                check("R9", 32'(dq_out), 32'd0);
            end
            if (cy == 1) check("R2", 32'(rd_err), 32'd0);
            rd_valid   = (cy == 0);
            rd_bank    = b;
            rd_col     = c;
            burst_stop = (stop_at > 0 && cy == stop_at);
            if (cy == 0) begin
                mode_bl = blc; mode_cl3 = cl3;
            end else if (scramble && cy == 1) begin
                mode_bl = blc ^ 3'b001; mode_cl3 = ~cl3;
            end
        end
        rd_valid = 1'b0; burst_stop = 1'b0;
    endtask

    task automatic closed_read(logic [1:0] b);
        for (int cy = 0; cy <= 6; cy++) begin
            @(negedge clk);
            if (cy >= 1) begin
                check("R7", 32'(rd_err), (cy == 1) ? 32'd1 : 32'd0);
                check("R7", 32'(dq_oe), 32'd0);
            end
            rd_valid = (cy == 0);
            rd_bank  = b;
            rd_col   = 9'd5;
            mode_bl  = 3'd3;
        end
        rd_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [2:0] codes [5] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd7};
        void'($urandom(32'h0000_5eed));
        repeat (3) @(negedge clk);
        check("R1", 32'(dq_oe), 32'd0);
        check("R1", 32'(rd_err), 32'd0);
        check("R1", 32'(dq_out), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 32'(dq_oe), 32'd0);

        closed_read(2'd3);                         // R7: nothing open yet
        for (int b = 0; b < 3; b++) activate(2'(b), 12'($urandom));
        closed_read(2'd3);                         // R7: bank 3 still closed

        run_read(2'd0, 9'd13, 3'd3, 1'b0, -1, 0);  // R3: 13..15 wrap to 8
        run_read(2'd1, 9'd13, 3'd3, 1'b1, -1, 0);
        run_read(2'd2, 9'd508, 3'd7, 1'b0, 8, 0);  // R6: 508..511, 0..3
        run_read(2'd2, 9'd510, 3'd7, 1'b1, 5, 0);
        run_read(2'd0, 9'd7, 3'd0, 1'b0, -1, 0);   // R5: single word
        run_read(2'd1, 9'd3, 3'd5, 1'b1, -1, 0);   // R3: reserved code
        run_read(2'd0, 9'd6, 3'd2, 1'b1, -1, 1);   // R8
        run_read(2'd1, 9'd100, 3'd7, 1'b0, 3, 1);  // R8 with page
        run_read(2'd2, 9'd9, 3'd3, 1'b0, 2, 0);    // R6: stop a fixed burst
        activate(2'd3, 12'h5a3);                   // R2
        run_read(2'd3, 9'd21, 3'd2, 1'b0, -1, 0);
        activate(2'd3, 12'h0c6);                   // R2: new row replaces old
        run_read(2'd3, 9'd21, 3'd2, 1'b1, -1, 0);

        for (int it = 0; it < 40; it++) begin
            logic [1:0] b    = 2'($urandom_range(0, 3));
            logic [2:0] code = codes[$urandom_range(0, 4)];
            int stop_at = -1;
            if (code == 3'd7) stop_at = $urandom_range(1, 12);
            else if ($urandom_range(0, 3) == 0) stop_at = $urandom_range(1, 4);
            if ($urandom_range(0, 5) == 0) activate(b, 12'($urandom));
            run_read(b, 9'($urandom), code, 1'($urandom), stop_at,
                     $urandom_range(0, 4) == 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule